// File: doc/BRIEF.md
# Issue-stage latency interlock

This block sits at the issue point of a single-issue, in-order pipeline. Each cycle it may receive one instruction. The request carries an operation class, a destination register and two source registers. The block compares the sources against the registers written by producers that issued recently. It grants issue only once each source has waited out the gap that its producer/consumer class pair needs. Until then it raises stall, and the issue logic upstream holds the instruction.

Each register slot holds a small countdown and the class of its last producer. When an instruction issues, the countdown is loaded with that producer's longest gap, and it then falls by one every cycle. A consumer is ready once the countdown has fallen to the slack left for its own kind of use. An FP ALU operand, an integer operand and a store's data operand can therefore see different waits behind the same producer.

Top module: `ilk_issue_interlock`

## Requirements
- R1: An FP ALU result (class code 3) read as a source by a later FP ALU operation stalls that consumer for exactly 3 cycles. The consumer issues in the fourth cycle after its producer issued.
- R2: An FP ALU result read as the data operand of a store (class code 2, source B) stalls the store for exactly 2 cycles.
- R3: A load result (class code 1) read by an FP ALU operation stalls that consumer for exactly 1 cycle.
- R4: A load result used as store data causes no stall. An integer result (class code 0) read by an integer operation causes no stall.
- R5: The base operand of a store (source A) counts as an integer use. A load result used as a store base stalls the store 1 cycle, while the same result used as its data would not stall it.
- R6: A register index is 6 bits: bit 5 set selects the FP file, and bits 4:0 give the register number. Index 0 (integer register zero) never causes a stall, and writing it records nothing.
- R7: A branch (class code 4) reads both sources as integer uses and writes no register. The instruction after it, the delay slot, goes through the normal data checks only and is never cancelled.
- R8: Operands that a class does not use are ignored: source B of a load, and the destination field of a store or a branch.
- R9: Grant is high exactly when a request is valid and all of its used sources are ready. Stall is high only with a valid request. A held instruction is granted in the first cycle its sources are ready.
- R10: Countdowns fall by one every cycle, whether or not anything issues, so idle cycles count toward a required gap.
- R11: A synchronous active-high reset clears every pending gap, so no register causes a stall right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | An instruction is presented this cycle |
| req_class | input | 3 | Class: 0 int, 1 load, 2 store, 3 FP ALU, 4 branch |
| req_dst | input | 6 | Destination register index |
| req_src_a | input | 6 | Source A (store/load base) |
| req_src_b | input | 6 | Source B (store data) |
| issue_stall | output | 1 | Instruction must be held this cycle |
| issue_grant | output | 1 | Instruction issues this cycle |

## Verification
The bench counts the exact number of stall cycles for each class pair, so a table entry that is off by one gives a stall that ends one cycle early or late. It puts a store behind a load twice, once with the result as the base and once as the data. A design that treats both store operands alike would stall both stores or neither. It also writes register zero, tags a branch with a destination, gives a load a busy source B, and lets cycles pass idle before a dependent instruction. A design that records these writes or reads, or that counts down only on issue, would then stall where it must not. A reset in the middle of a pending gap checks that no stale countdown survives.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    localparam int REG_W     = 5;
    localparam int IDX_W     = REG_W + 1;
    localparam int NUM_SLOTS = 2 ** IDX_W;

    // producer -> consumer gaps in stall cycles
    localparam int LAT_FALU_FALU  = 3;
    localparam int LAT_FALU_SDATA = 2;
    localparam int LAT_FALU_INT   = 3;
    localparam int LAT_LOAD_FALU  = 1;
    localparam int LAT_LOAD_INT   = 1;
    localparam int LAT_LOAD_SDATA = 0;
    localparam int LAT_INT_ANY    = 0;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int MAX_GAP = imax(imax(imax(LAT_FALU_FALU, LAT_FALU_SDATA), LAT_FALU_INT),
                                  imax(imax(LAT_LOAD_FALU, LAT_LOAD_INT),
                                       imax(LAT_LOAD_SDATA, LAT_INT_ANY)));
    localparam int CNT_W = (MAX_GAP < 1) ? 1 : $clog2(MAX_GAP + 1);

    typedef logic [CNT_W-1:0] gap_t;
    typedef logic [IDX_W-1:0] reg_idx_t;

    typedef enum logic [2:0] {
        CLS_INT    = 3'd0,
        CLS_LOAD   = 3'd1,
        CLS_STORE  = 3'd2,
        CLS_FALU   = 3'd3,
        CLS_BRANCH = 3'd4
    } op_class_e;

    typedef enum logic [1:0] {PK_INT, PK_LOAD, PK_FALU} prod_kind_e;
    typedef enum logic [1:0] {UK_INT, UK_FALU, UK_SDATA} use_kind_e;

    function automatic int gap_int(prod_kind_e p, use_kind_e u);
        case (p)
            PK_FALU: case (u)
                UK_FALU:  return LAT_FALU_FALU;
                UK_SDATA: return LAT_FALU_SDATA;
                default:  return LAT_FALU_INT;
            endcase
            PK_LOAD: case (u)
                UK_FALU:  return LAT_LOAD_FALU;
                UK_SDATA: return LAT_LOAD_SDATA;
                default:  return LAT_LOAD_INT;
            endcase
            default: return LAT_INT_ANY;
        endcase
    endfunction

    function automatic gap_t gap_of(prod_kind_e p, use_kind_e u);
        return gap_t'(gap_int(p, u));
    endfunction

    function automatic gap_t full_of(prod_kind_e p);
        return gap_t'(imax(imax(gap_int(p, UK_INT), gap_int(p, UK_FALU)), gap_int(p, UK_SDATA)));
    endfunction

    function automatic logic writes_dst(op_class_e c);
        return (c == CLS_INT) || (c == CLS_LOAD) || (c == CLS_FALU);
    endfunction

    function automatic prod_kind_e prod_of(op_class_e c);
        case (c)
            CLS_LOAD: return PK_LOAD;
            CLS_FALU: return PK_FALU;
            default:  return PK_INT;
        endcase
    endfunction

    function automatic logic uses_b(op_class_e c);
        return (c == CLS_INT) || (c == CLS_STORE) || (c == CLS_FALU) || (c == CLS_BRANCH);
    endfunction

    function automatic use_kind_e use_a(op_class_e c);
        return (c == CLS_FALU) ? UK_FALU : UK_INT;
    endfunction

    function automatic use_kind_e use_b(op_class_e c);
        case (c)
            CLS_FALU:  return UK_FALU;
            CLS_STORE: return UK_SDATA;
            default:   return UK_INT;
        endcase
    endfunction

endpackage

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard
    import ilk_pkg::*;
#(
    parameter int NUM_RD = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  reg_idx_t   wr_idx,
    input  prod_kind_e wr_kind,
    input  reg_idx_t   rd_idx  [NUM_RD],
    output gap_t       rd_cnt  [NUM_RD],
    output prod_kind_e rd_kind [NUM_RD]
);

    gap_t       cnt_q  [NUM_SLOTS];
    prod_kind_e kind_q [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q[s]  <= '0;
                kind_q[s] <= PK_INT;
            end else if (wr_en && (wr_idx == reg_idx_t'(s))) begin
                cnt_q[s]  <= full_of(wr_kind);
                kind_q[s] <= wr_kind;
            end else if (cnt_q[s] != '0) begin
                cnt_q[s]  <= cnt_q[s] - gap_t'(1);
            end
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rd_cnt[p]  = cnt_q[rd_idx[p]];
        assign rd_kind[p] = kind_q[rd_idx[p]];
    end

    AST_SET_FULL: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cnt_q[$past(wr_idx)] == full_of($past(wr_kind))); // R10

    AST_SLOT0_IDLE: assert property (@(posedge clk) disable iff (rst)
        cnt_q[0] == '0); // R6

endmodule

// File: rtl/ilk_src_check.sv
module ilk_src_check
    import ilk_pkg::*;
(
    input  logic       used,
    input  use_kind_e  use_kind,
    input  gap_t       cnt,
    input  prod_kind_e prod_kind,
    output logic       ready
);

    gap_t slack;

    always_comb begin
        slack = full_of(prod_kind) - gap_of(prod_kind, use_kind);
        ready = !used || (cnt <= slack);
    end

endmodule

// File: rtl/ilk_issue_interlock.sv
module ilk_issue_interlock
    import ilk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [2:0]       req_class,
    input  logic [IDX_W-1:0] req_dst,
    input  logic [IDX_W-1:0] req_src_a,
    input  logic [IDX_W-1:0] req_src_b,
    output logic             issue_stall,
    output logic             issue_grant
);

    localparam int NUM_SRC = 2;

    op_class_e         cls;
    reg_idx_t          src_idx  [NUM_SRC];
    gap_t              src_cnt  [NUM_SRC];
    prod_kind_e        src_kind [NUM_SRC];
    use_kind_e         src_use  [NUM_SRC];
    logic [NUM_SRC-1:0] src_used;
    logic [NUM_SRC-1:0] src_ready;
    logic              all_ready;
    logic              wr_en;

    always_comb begin
        cls         = op_class_e'(req_class);
        src_idx[0]  = req_src_a;
        src_idx[1]  = req_src_b;
        src_use[0]  = use_a(cls);
        src_use[1]  = use_b(cls);
        src_used[0] = 1'b1;
        src_used[1] = uses_b(cls);
    end

    ilk_scoreboard #(.NUM_RD(NUM_SRC)) u_board (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (req_dst),
        .wr_kind (prod_of(cls)),
        .rd_idx  (src_idx),
        .rd_cnt  (src_cnt),
        .rd_kind (src_kind)
    );

    for (genvar p = 0; p < NUM_SRC; p++) begin : g_src
        ilk_src_check u_chk (
            .used      (src_used[p]),
            .use_kind  (src_use[p]),
            .cnt       (src_cnt[p]),
            .prod_kind (src_kind[p]),
            .ready     (src_ready[p])
        );
    end

    always_comb begin
        all_ready   = &src_ready;
        issue_stall = req_valid && !all_ready;
        issue_grant = req_valid && all_ready;
        wr_en       = issue_grant && writes_dst(cls) && (req_dst != '0);
    end

    AST_FALU_CHAIN: assert property (@(posedge clk) disable iff (rst)
        (issue_grant && cls == CLS_FALU && req_dst != '0) |=>
        (!(req_valid && op_class_e'(req_class) == CLS_FALU && req_src_a == $past(req_dst))
         || issue_stall)); // R1

    AST_FALU_STORE_DATA: assert property (@(posedge clk) disable iff (rst)
        (issue_grant && cls == CLS_FALU && req_dst != '0) |=>
        (!(req_valid && op_class_e'(req_class) == CLS_STORE && req_src_b == $past(req_dst))
         || issue_stall)); // R2

    AST_LOAD_BASE: assert property (@(posedge clk) disable iff (rst)
        (issue_grant && cls == CLS_LOAD && req_dst != '0 && !req_dst[IDX_W-1]) |=>
        (!(req_valid && op_class_e'(req_class) == CLS_STORE && req_src_a == $past(req_dst))
         || issue_stall)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!issue_grant && !issue_stall)); // R9

endmodule

// File: tb/ilk_issue_interlock_bench.sv
`timescale 1ns/1ps
module ilk_issue_interlock_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [2:0] req_class;
    logic [5:0] req_dst, req_src_a, req_src_b;
    logic       issue_stall, issue_grant;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #2.5 clk = ~clk;

    ilk_issue_interlock u_ilk_issue_interlock (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
        .req_dst(req_dst), .req_src_a(req_src_a), .req_src_b(req_src_b),
        .issue_stall(issue_stall), .issue_grant(issue_grant)
    );

    // {valid, class, dst, src_a, src_b, expected stall}; FP reg k = 32 + k
    localparam int NV = 32;
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 3'd3, 6'd33, 6'd34, 6'd35, 1'b0},  // R1 producer
        {1'b1, 3'd3, 6'd36, 6'd33, 6'd34, 1'b1},  // R1
        {1'b1, 3'd3, 6'd36, 6'd33, 6'd34, 1'b1},
        {1'b1, 3'd3, 6'd36, 6'd33, 6'd34, 1'b1},
        {1'b1, 3'd3, 6'd36, 6'd33, 6'd34, 1'b0},
        {1'b1, 3'd2, 6'd0,  6'd5,  6'd36, 1'b1},  // R2
        {1'b1, 3'd2, 6'd0,  6'd5,  6'd36, 1'b1},
        {1'b1, 3'd2, 6'd0,  6'd5,  6'd36, 1'b0},
        {1'b1, 3'd1, 6'd38, 6'd2,  6'd0,  1'b0},  // R3 producer
        {1'b1, 3'd3, 6'd39, 6'd38, 6'd34, 1'b1},  // R3
        {1'b1, 3'd3, 6'd39, 6'd38, 6'd34, 1'b0},
        {1'b1, 3'd1, 6'd40, 6'd3,  6'd0,  1'b0},  // R4
        {1'b1, 3'd2, 6'd0,  6'd3,  6'd40, 1'b0},  // R4 load -> store data
        {1'b1, 3'd0, 6'd9,  6'd1,  6'd2,  1'b0},
        {1'b1, 3'd0, 6'd10, 6'd9,  6'd9,  1'b0},  // R4 int -> int
        {1'b1, 3'd0, 6'd11, 6'd0,  6'd0,  1'b0},  // R6
        {1'b1, 3'd1, 6'd12, 6'd1,  6'd0,  1'b0},  // R5
        {1'b1, 3'd2, 6'd0,  6'd12, 6'd13, 1'b1},  // R5 base stalls
        {1'b1, 3'd2, 6'd0,  6'd12, 6'd13, 1'b0},
        {1'b1, 3'd1, 6'd13, 6'd1,  6'd0,  1'b0},
        {1'b1, 3'd2, 6'd0,  6'd1,  6'd13, 1'b0},  // R5 data does not
        {1'b1, 3'd1, 6'd0,  6'd1,  6'd0,  1'b0},  // R6 write to r0
        {1'b1, 3'd0, 6'd14, 6'd0,  6'd0,  1'b0},  // R6
        {1'b1, 3'd1, 6'd15, 6'd1,  6'd0,  1'b0},  // R7
        {1'b1, 3'd4, 6'd20, 6'd15, 6'd0,  1'b1},  // R7 branch int use
        {1'b1, 3'd4, 6'd20, 6'd15, 6'd0,  1'b0},
        {1'b1, 3'd0, 6'd21, 6'd20, 6'd20, 1'b0},  // R7 delay slot
        {1'b1, 3'd3, 6'd41, 6'd34, 6'd35, 1'b0},  // R8
        {1'b1, 3'd1, 6'd16, 6'd1,  6'd41, 1'b0},  // R8 load src B ignored
        {1'b0, 3'd3, 6'd42, 6'd41, 6'd41, 1'b0},  // R9 idle
        {1'b1, 3'd3, 6'd42, 6'd41, 6'd34, 1'b1},  // R10
        {1'b1, 3'd3, 6'd42, 6'd41, 6'd34, 1'b0}
    };

    function automatic string row_tag(int r);
        if (r <= 4)  return "R1";
        if (r <= 7)  return "R2";
        if (r <= 10) return "R3";
        if (r <= 14) return "R4";
        if (r == 15) return "R6";
        if (r <= 20) return "R5";
        if (r <= 22) return "R6";
        if (r <= 26) return "R7";
        if (r <= 28) return "R8";
        if (r == 29) return "R9";
        return "R10";
    endfunction

    task automatic check(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic drive(logic v, logic [2:0] c, logic [5:0] d, logic [5:0] a, logic [5:0] b);
        @(negedge clk);
        req_valid = v; req_class = c; req_dst = d; req_src_a = a; req_src_b = b;
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_class = '0;
        req_dst = '0; req_src_a = '0; req_src_b = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R11", "reset stall", issue_stall, 1'b0);
        check("R11", "reset grant", issue_grant, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [22:0] v;
            v = VEC[i];
            drive(v[22], v[21:19], v[18:13], v[12:7], v[6:1]);
            check(row_tag(i), $sformatf("row %0d stall", i), issue_stall, v[0]);
            check(row_tag(i), $sformatf("row %0d grant", i), issue_grant, v[22] & ~v[0]);
        end

        // R11: reset in the middle of a pending FP gap
        drive(1'b1, 3'd3, 6'd52, 6'd34, 6'd35);
        check("R11", "producer grant", issue_grant, 1'b1);
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        #1;
        check("R11", "in-reset stall", issue_stall, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        req_valid = 1'b1; req_class = 3'd3; req_dst = 6'd53;
        req_src_a = 6'd52; req_src_b = 6'd34;
        #1;
        check("R11", "after-reset stall", issue_stall, 1'b0);
        check("R11", "after-reset grant", issue_grant, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule